// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor Table

This block holds one small saturating state per table slot and turns it into a taken or not-taken guess for a conditional jump. The fetch side presents a branch address on the lookup port and gets a direction back in the same cycle. The execute side reports each resolved conditional jump on the update port with its address and real outcome. The table then moves the addressed slot one step toward that outcome on the next clock edge. The update port also reports, in the same cycle, whether the guess made for that branch was wrong.

Each port has a per-access static select. When it is set, the instruction's own hint bit is the guess and the table is bypassed. A static update leaves the table untouched. A dynamic entry reverses its guess only after two wrong outcomes in a row from a strong state. A loop branch therefore costs one wrong guess per loop exit once it has warmed up.

Top module: `bpred_table`

## Requirements
- R1: Each slot holds a 2-bit state: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. A dynamic lookup predicts taken exactly when bit 1 of the addressed state is 1.
- R2: A dynamic update whose outcome matches the stored guess moves a weak state to the strong state of the same direction. A strong state stays where it is.
- R3: A wrong outcome on a strong state moves it to the weak state of the same direction, so the guess does not change. Two wrong outcomes in a row are needed to reverse a strong guess, and the guess never changes without a dynamic misprediction.
- R4: A wrong outcome on a weak state moves it to the weak state of the opposite direction (01 to 10 on taken, 10 to 01 on not-taken).
- R5: The slot index is address bits [IDX_LSB+IDX_W-1:IDX_LSB], with bits [7:2] by default. Addresses that differ only outside these bits share a slot, and an update touches no other slot.
- R6: A synchronous active-low reset sets every slot to weak not-taken (01).
- R7: Lookup is combinational. When a lookup and an update address the same slot in one cycle, the lookup returns the state from before the update. The new state is visible from the cycle after the clock edge.
- R8: up_mispredict is high in the update cycle exactly when up_valid is high and the guess differs from up_outcome. The guess is the stored bit 1 in dynamic mode and up_hint in static mode. up_mispredict is low whenever up_valid is low.
- R9: A static lookup returns lk_hint whatever the table holds.
- R10: A static update leaves every slot unchanged.
- R11: For a loop branch taken N times and then not taken once, every loop after the first has exactly one dynamic misprediction, at the exit.
- R12: While up_valid is low, no slot changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | Address of the branch being looked up |
| lk_static | input | 1 | 1: use lk_hint instead of the table |
| lk_hint | input | 1 | Hint bit taken from the instruction |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A conditional jump resolved this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_static | input | 1 | 1: the branch was predicted by its hint; the table is not written |
| up_hint | input | 1 | Hint bit of the resolved branch |
| up_outcome | input | 1 | Real direction, 1 = taken |
| up_mispredict | output | 1 | The guess for the resolved branch was wrong |

## Verification
The properties assume that up_valid, up_static and up_outcome are stable across each rising edge and that every update bit is a defined value. They also assume that reset is held for at least one edge before the first access. The stimulus meets these assumptions: every input changes only on the falling edge, all inputs are driven to known values before reset is released, and reset is held for several cycles. Update and lookup addresses are chosen freely, including the same slot in the same cycle and aliases that differ above the index field. The properties must therefore hold under any ordering of accesses.

// File: rtl/bpred_pkg.sv
// Shared types for the branch direction table.
// Assumes nothing beyond a 2-bit state per slot.
package bpred_pkg;

    // State encoding; bit 1 is the predicted direction.
    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    localparam ctr_e CTR_RESET = CTR_WNT;

endpackage

// File: rtl/bpred_ctr_next.sv
// Next-state rule for one slot: step toward the resolved outcome,
// saturating at the strong ends. Purely combinational.
module bpred_ctr_next
    import bpred_pkg::*;
(
    input  logic [1:0] cur_state,
    input  logic       outcome,
    output logic [1:0] nxt_state
);

    ctr_e cur;
    ctr_e nxt;

    assign cur       = ctr_e'(cur_state);
    assign nxt_state = nxt;

    // Select the next state from the current state and the real direction.
    always_comb begin
        unique case (cur)
            CTR_SNT: nxt = outcome ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = outcome ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = outcome ? CTR_ST  : CTR_WNT;
            default: nxt = outcome ? CTR_ST  : CTR_WT;
        endcase
    end

endmodule

// File: rtl/bpred_store.sv
// Storage of N_ENT 2-bit slots with a single write port.
// Assumes wr_idx is below N_ENT whenever wr_en is high.
module bpred_store
    import bpred_pkg::*;
#(
    parameter int IDX_W = 6,
    localparam int N_ENT = 1 << IDX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [1:0]         wr_val,
    output logic [2*N_ENT-1:0] state_flat
);

    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        logic [1:0] slot_q;

        // Reset to weak not-taken; load when this slot is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= CTR_RESET;
            else if (wr_en && (wr_idx == IDX_W'(g)))
                slot_q <= wr_val;
        end

        assign state_flat[2*g +: 2] = slot_q;
    end

endmodule

// File: rtl/bpred_read.sv
// Combinational read of one slot from the flattened state vector.
// Assumes idx addresses an existing slot.
module bpred_read #(
    parameter int IDX_W = 6,
    localparam int N_ENT = 1 << IDX_W
) (
    input  logic [2*N_ENT-1:0] state_flat,
    input  logic [IDX_W-1:0]   idx,
    output logic [1:0]         state
);

    // Pick the two bits of the addressed slot.
    always_comb begin
        state = state_flat[{idx, 1'b0} +: 2];
    end

endmodule

// File: rtl/bpred_table.sv
// Direct-mapped two-bit branch direction table with a lookup port and
// an update port. Each port can bypass the table with an instruction hint.
// Assumes at most one resolved branch per cycle.
module bpred_table #(
    parameter int PC_W    = 32,
    parameter int IDX_W   = 6,
    parameter int IDX_LSB = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_static,
    input  logic            lk_hint,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_static,
    input  logic            up_hint,
    input  logic            up_outcome,
    output logic            up_mispredict
);

    localparam int N_ENT = 1 << IDX_W;

    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   up_idx;
    logic [1:0]         lk_state;
    logic [1:0]         up_state;
    logic [1:0]         up_next;
    logic               up_guess;
    logic               tbl_wr;
    logic [2*N_ENT-1:0] state_flat;

    assign lk_idx = lk_pc[IDX_LSB +: IDX_W];
    assign up_idx = up_pc[IDX_LSB +: IDX_W];

    bpred_store #(.IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (tbl_wr),
        .wr_idx     (up_idx),
        .wr_val     (up_next),
        .state_flat (state_flat)
    );

    bpred_read #(.IDX_W(IDX_W)) u_rd_lk (
        .state_flat (state_flat),
        .idx        (lk_idx),
        .state      (lk_state)
    );

    bpred_read #(.IDX_W(IDX_W)) u_rd_up (
        .state_flat (state_flat),
        .idx        (up_idx),
        .state      (up_state)
    );

    bpred_ctr_next u_next (
        .cur_state (up_state),
        .outcome   (up_outcome),
        .nxt_state (up_next)
    );

    // Lookup direction: hint in static mode, stored bit 1 otherwise.
    always_comb begin
        lk_taken = lk_static ? lk_hint : lk_state[1];
    end

    // Update side: guess that was made, misprediction flag, write enable.
    always_comb begin
        up_guess      = up_static ? up_hint : up_state[1];
        up_mispredict = up_valid && (up_guess != up_outcome);
        tbl_wr        = up_valid && !up_static;
    end

endmodule

// File: rtl/bpred_table_chk.sv
// Property checker for bpred_table, attached by bind.
// Assumes the flattened state vector of the table is visible.
module bpred_table_chk #(
    parameter int N_ENT = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               up_valid,
    input logic               up_static,
    input logic               up_mispredict,
    input logic [2*N_ENT-1:0] state_flat
);

    logic [N_ENT-1:0] pred_vec;

    // Gather the direction bit of every slot.
    always_comb begin
        for (int i = 0; i < N_ENT; i++) pred_vec[i] = state_flat[2*i+1];
    end

    p_reset_weak_nt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> state_flat == {N_ENT{2'b01}});

    p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(state_flat));

    p_static_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_static) |=> $stable(state_flat));

    p_flip_needs_miss_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_valid && !up_static && up_mispredict) |=> $stable(pred_vec));

    p_idle_no_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |-> !up_mispredict);

endmodule

bind bpred_table bpred_table_chk #(.N_ENT(N_ENT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .up_valid      (up_valid),
    .up_static     (up_static),
    .up_mispredict (up_mispredict),
    .state_flat    (state_flat)
);

// File: tb/bpred_table_bench.sv
// Scoreboard bench: the driver pushes expected results, the monitor compares.
module bpred_table_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_LOOP     = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_static = 1'b0;
    logic        lk_hint = 1'b0;
    logic        lk_taken;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_static = 1'b0;
    logic        up_hint = 1'b0;
    logic        up_outcome = 1'b0;
    logic        up_mispredict;

    typedef struct {
        logic  exp_pred;
        logic  exp_mis;
        string tag_lk;
        string tag_up;
    } item_t;

    item_t    sb_q[$];
    logic [1:0] model [64];
    int n_chk = 0;
    int n_fail = 0;
    int obs_mis = 0;
    event ev_sample;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpred_table u_bpred_table (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_static(lk_static), .lk_hint(lk_hint), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_static(up_static),
        .up_hint(up_hint), .up_outcome(up_outcome), .up_mispredict(up_mispredict)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected item per sample event and compare.
    initial begin
        item_t it;
        forever begin
            @(ev_sample);
            it = sb_q.pop_front();
            check(lk_taken, it.exp_pred, it.tag_lk);
            check(up_mispredict, it.exp_mis, it.tag_up);
            if (up_mispredict) obs_mis++;
        end
    end

    function automatic logic [1:0] ctr_step(input logic [1:0] s, input logic t);
        if (t) return (s == 2'b11) ? 2'b11 : s + 2'd1;
        return (s == 2'b00) ? 2'b00 : s - 2'd1;
    endfunction

    // Driver: one cycle of lookup and update, with expected values from the model.
    task automatic step(input logic uv, input logic [31:0] upc, input logic ust,
                        input logic uh, input logic uo, input logic [31:0] lpc,
                        input logic lst, input logic lh, input string tag_lk);
        item_t it;
        int li;
        int ui;
        logic guess;
        @(negedge clk);
        up_valid = uv; up_pc = upc; up_static = ust; up_hint = uh; up_outcome = uo;
        lk_pc = lpc; lk_static = lst; lk_hint = lh;
        li = int'(lpc[7:2]);
        ui = int'(upc[7:2]);
        it.exp_pred = lst ? lh : model[li][1];
        guess = ust ? uh : model[ui][1];
        it.exp_mis = uv && (guess != uo);
        it.tag_lk = tag_lk;
        if (!uv)       it.tag_up = "R12 idle flag";
        else if (ust)  it.tag_up = "R8 static flag";
        else if (model[ui] == 2'b00 || model[ui] == 2'b11)
            it.tag_up = (guess == uo) ? "R2 strong hold" : "R3 strong miss";
        else
            it.tag_up = (guess == uo) ? "R2 weak to strong" : "R4 weak miss";
        sb_q.push_back(it);
        #2 -> ev_sample;
        #1;
        if (uv && !ust) model[ui] = ctr_step(model[ui], uo);
    endtask

    task automatic look(input logic [31:0] lpc, input string tag);
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, lpc, 1'b0, 1'b0, tag);
    endtask

    task automatic upd(input logic [31:0] upc, input logic uo, input string tag);
        step(1'b1, upc, 1'b0, 1'b0, uo, upc, 1'b0, 1'b0, tag);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R11: actual hang expected completion");
        report();
    end

    initial begin
        int m0;
        for (int i = 0; i < 64; i++) model[i] = 2'b01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: every slot reads weak not-taken after reset.
        for (int i = 0; i < 64; i++) look(32'(i * 4), "R6 reset state");

        // R1 R2 R3 R4: walk slot at 0x10 through the states.
        upd(32'h10, 1'b1, "R1 lookup before taken");   // 01 -> 10
        look(32'h10, "R4 weak nt to weak t");
        upd(32'h10, 1'b1, "R1 weak taken");            // 10 -> 11
        upd(32'h10, 1'b1, "R1 strong taken");          // 11 -> 11
        upd(32'h10, 1'b0, "R1 strong taken");          // 11 -> 10
        look(32'h10, "R3 single miss keeps taken");
        upd(32'h10, 1'b0, "R3 weak taken");            // 10 -> 01
        look(32'h10, "R3 two misses flip");
        upd(32'h10, 1'b0, "R2 weak nt");               // 01 -> 00
        upd(32'h10, 1'b0, "R2 strong nt");             // 00 -> 00
        upd(32'h10, 1'b1, "R2 strong nt");             // 00 -> 01
        look(32'h10, "R3 strong nt single miss");

        // R7: same slot looked up and updated in one cycle returns the old state.
        upd(32'h20, 1'b1, "R7 same cycle old value");  // 01 -> 10
        look(32'h20, "R7 new value after edge");

        // R5: aliasing above the index field, and neighbours untouched.
        upd(32'h0000_0124, 1'b1, "R5 alias write");   // slot 9 -> 10
        look(32'h0000_0024, "R5 alias shares slot");
        look(32'h0000_0028, "R5 neighbour unchanged");
        look(32'h0000_0020, "R5 other slot unchanged");

        // R9: static lookup follows the hint against the table.
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h24, 1'b1, 1'b0, "R9 static hint 0");
        step(1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 32'h30, 1'b1, 1'b1, "R9 static hint 1");

        // R10 R8: static updates do not touch the slot; flag follows the hint.
        for (int i = 0; i < 4; i++)
            step(1'b1, 32'h30, 1'b1, 1'b0, 1'b1, 32'h30, 1'b0, 1'b0, "R10 static update");
        step(1'b1, 32'h30, 1'b1, 1'b1, 1'b1, 32'h30, 1'b0, 1'b0, "R10 static update");
        look(32'h30, "R10 slot unchanged");

        // R12: outcome present without up_valid changes nothing.
        for (int i = 0; i < 3; i++)
            step(1'b0, 32'h34, 1'b0, 1'b0, 1'b1, 32'h34, 1'b0, 1'b0, "R12 idle update");
        look(32'h34, "R12 slot unchanged");

        // R11: loop branch, dynamic.
        for (int lp = 0; lp < 4; lp++) begin
            m0 = obs_mis;
            for (int k = 0; k < N_LOOP; k++) upd(32'h80, 1'b1, "R11 loop body");
            upd(32'h80, 1'b0, "R11 loop exit");
            if (lp > 0) check(1'b1, (obs_mis - m0) == 1, "R11 one miss per loop");
        end

        // R11 R8: static hint comparison over the same loop shape.
        m0 = obs_mis;
        for (int k = 0; k < N_LOOP; k++)
            step(1'b1, 32'h84, 1'b1, 1'b1, 1'b1, 32'h84, 1'b1, 1'b1, "R9 loop static");
        step(1'b1, 32'h84, 1'b1, 1'b1, 1'b0, 32'h84, 1'b1, 1'b1, "R9 loop static");
        check(1'b1, (obs_mis - m0) == 1, "R8 static taken hint one miss");
        m0 = obs_mis;
        for (int k = 0; k < N_LOOP; k++)
            step(1'b1, 32'h84, 1'b1, 1'b0, 1'b1, 32'h84, 1'b1, 1'b0, "R9 loop static");
        step(1'b1, 32'h84, 1'b1, 1'b0, 1'b0, 32'h84, 1'b1, 1'b0, "R9 loop static");
        check(1'b1, (obs_mis - m0) == N_LOOP, "R8 static nt hint misses body");
        look(32'h84, "R10 static loop left slot");

        @(negedge clk);
        report();
    end

endmodule